// File: doc/BRIEF.md
# Infrared Transceiver Mode Controller

This block is the digital control core of an infrared serial transceiver. It takes three asynchronous inputs: the transmit-data line, the shutdown request, and the comparator output that marks detected light. From these it drives the LED enable, the value of the receive-data pin, and an output enable for that pin. When the block is asleep the enable is released and an external weak pull-up holds the line high.

The shutdown request takes effect only after a hold delay. While that delay runs, a falling edge on transmit data fires a fixed-width low identification pulse on the receive pin. When the block is awake, a rising edge of detected light produces one fixed-width low receive pulse. The receiver is blanked whenever transmit data is high. An eye-safety timer cuts the LED if transmit data stays high too long. After the shutdown request is withdrawn, a wake-up delay runs before reception resumes. Every time is a parameter in clock cycles, derived from the clock frequency parameter `CLK_HZ`. The hold delay is 1 ms, the wake delay 50 µs, the eye-safety limit 40 µs and the receive pulse 400 ns.

Top module: `irtrx_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `led_on` is 0, `rxd_val` is 1 and `rxd_oe` is 1. The block starts awake with all timers cleared.
- R2: When awake, `led_on` follows `txd_in` with a latency of three clock cycles (two synchronizer stages and one output register).
- R3: Each high period of `txd_in` lights the LED for at most `EYE_CYC` cycles. After that the LED stays off until `txd_in` goes low, and the next high period lights it again.
- R4: When awake with `txd_in` low, a rising edge of `light_in` drives `rxd_val` low for exactly `PULSE_CYC` cycles, starting three cycles after the edge. Steady light, absent light and falling edges leave `rxd_val` at 1.
- R5: A rising edge of `light_in` that arrives while a receive pulse is running is ignored and does not stretch or restart the pulse.
- R6: While `txd_in` is high, `rxd_val` stays 1 and light edges produce no pulse.
- R7: The block shuts down only when `sd_in` has been held high for `SD_CYC` cycles. Shutdown is seen as `rxd_oe` at 0, exactly `SD_CYC + 3` cycles after `sd_in` rises. A shorter high period leaves the block awake.
- R8: While the shutdown delay is running, `led_on` is 0, and a falling edge of `txd_in` produces one `rxd_val` low pulse of `PULSE_CYC` cycles, three cycles after the edge.
- R9: In shutdown, `rxd_oe` is 0, `rxd_val` is 1 and `led_on` is 0, whatever `txd_in` and `light_in` do.
- R10: Three cycles after `sd_in` falls, `rxd_oe` returns to 1. For the next `WAKE_CYC` cycles, `rxd_val` stays 1 and light edges are ignored. After that, reception works as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| txd_in | input | 1 | Transmit data, asynchronous, high lights the LED |
| sd_in | input | 1 | Shutdown request, asynchronous, active high |
| light_in | input | 1 | Comparator output, asynchronous, high when light is detected |
| led_on | output | 1 | LED drive enable |
| rxd_val | output | 1 | Value of the receive-data pin, low during a pulse |
| rxd_oe | output | 1 | Receive pin drive enable, 0 in shutdown |

## Verification
The assertions assume that each asynchronous input has been through the two-flop synchronizer, so every edge they see is a clean single-cycle event. They also assume that the timer parameters are at least one cycle. The receive pulse must be long enough for a second light edge to land inside it. The stimulus changes inputs only on the falling clock edge. It holds each level for at least one full cycle, keeps transmit pulses used for blanking shorter than the eye-safety limit, and overrides `CLK_HZ` so that the shutdown hold still runs its full length within the run. A retrigger pattern places a light edge two cycles into a running pulse.

// File: rtl/irx_pkg.sv
package irx_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SD_WAIT = 2'd1,
    MODE_OFF     = 2'd2,
    MODE_WAKE    = 2'd3
  } irx_mode_e;

  // Converts a duration in nanoseconds to clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1000000000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
    end
  end

endmodule

// File: rtl/irx_mode_ctrl.sv
module irx_mode_ctrl
  import irx_pkg::*;
#(
  parameter int unsigned SD_CYC   = 50000,
  parameter int unsigned WAKE_CYC = 2500
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sd_s,
  output irx_mode_e mode
);

  localparam int unsigned MAXC = (SD_CYC > WAKE_CYC) ? SD_CYC : WAKE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam int RW = CW + 1;
  localparam logic [CW-1:0] SD_LAST   = CW'(SD_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

  irx_mode_e     mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q + CW'(1);
    cnt_en = 1'b0;
    case (mode_q)
      MODE_RUN: begin
        if (sd_s) begin
          mode_d = MODE_SD_WAIT;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      MODE_SD_WAIT: begin
        if (!sd_s)                 mode_d = MODE_RUN;
        else if (cnt_q == SD_LAST) mode_d = MODE_OFF;
        else                       cnt_en = 1'b1;
      end
      MODE_OFF: begin
        if (!sd_s) begin
          mode_d = MODE_WAKE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      default: begin
        if (sd_s) begin
          mode_d = MODE_SD_WAIT;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else if (cnt_q == WAKE_LAST) begin
          mode_d = MODE_RUN;
        end else begin
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign mode = mode_q;

  // Independent run-length counters of the synchronized request level.
  logic [RW-1:0] hi_run_q, lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      if (!sd_s) hi_run_q <= '0;
      else if (hi_run_q != RW'(SD_CYC + 1)) hi_run_q <= hi_run_q + RW'(1);
      if (sd_s) lo_run_q <= '0;
      else if (lo_run_q != RW'(WAKE_CYC + 1)) lo_run_q <= lo_run_q + RW'(1);
    end
  end

  AST_OFF_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF && $past(mode_q) != MODE_OFF) |-> (hi_run_q >= RW'(SD_CYC))); // R7

  AST_RUN_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && $past(mode_q) == MODE_WAKE) |-> (lo_run_q >= RW'(WAKE_CYC))); // R10

endmodule

// File: rtl/irx_eye_limit.sv
module irx_eye_limit #(
  parameter int unsigned EYE_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  input  logic allow,
  output logic led_q
);

  localparam int EW = $clog2(EYE_CYC + 1);
  localparam logic [EW-1:0] EYE_MAX = EW'(EYE_CYC);

  logic [EW-1:0] eye_cnt_q, eye_cnt_d;
  logic          led_d;

  always_comb begin
    if (!txd_s)                 eye_cnt_d = '0;
    else if (eye_cnt_q == EYE_MAX) eye_cnt_d = eye_cnt_q;
    else                        eye_cnt_d = eye_cnt_q + EW'(1);
    led_d = allow && txd_s && (eye_cnt_q < EYE_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eye_cnt_q <= '0;
      led_q     <= 1'b0;
    end else begin
      eye_cnt_q <= eye_cnt_d;
      led_q     <= led_d;
    end
  end

  logic [EW-1:0] led_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      led_run_q <= '0;
    else if (!led_q)                 led_run_q <= '0;
    else if (led_run_q != EYE_MAX)   led_run_q <= led_run_q + EW'(1);
  end

  AST_EYE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    led_q |-> (led_run_q < EYE_MAX)); // R3

  AST_LED_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    led_q |-> $past(txd_s)); // R2

endmodule

// File: rtl/irx_rx_oneshot.sv
module irx_rx_oneshot #(
  parameter int unsigned PULSE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic clear,
  output logic busy
);

  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYC - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - PW'(1);
        cnt_en = 1'b1;
      end
    end else if (trig) begin
      busy_d = 1'b1;
      cnt_d  = P_LAST;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;

  logic [PW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            low_run_q <= '0;
    else if (!busy_q)                      low_run_q <= '0;
    else if (low_run_q != PW'(PULSE_CYC))  low_run_q <= low_run_q + PW'(1);
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (low_run_q < PW'(PULSE_CYC))); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && busy_q) |-> (cnt_q < $past(cnt_q))); // R5

endmodule

// File: rtl/irtrx_ctrl.sv
module irtrx_ctrl
  import irx_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic sd_in,
  input  logic light_in,
  output logic led_on,
  output logic rxd_val,
  output logic rxd_oe
);

  localparam int unsigned SD_CYC    = ns_to_cyc(CLK_HZ, 1000000);
  localparam int unsigned WAKE_CYC  = ns_to_cyc(CLK_HZ, 50000);
  localparam int unsigned EYE_CYC   = ns_to_cyc(CLK_HZ, 40000);
  localparam int unsigned PULSE_CYC = ns_to_cyc(CLK_HZ, 400);

  logic [2:0] raw_in, sync_q;
  logic       txd_s, sd_s, lit_s;
  logic       txd_prev_q, lit_prev_q;
  logic       txd_fall, lit_rise;
  irx_mode_e  mode;
  logic       tx_allow, rx_trig, rx_clear, rx_busy;

  assign raw_in = {light_in, sd_in, txd_in};

  irx_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_q)
  );

  assign txd_s = sync_q[0];
  assign sd_s  = sync_q[1];
  assign lit_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_prev_q <= 1'b0;
      lit_prev_q <= 1'b0;
    end else begin
      txd_prev_q <= txd_s;
      lit_prev_q <= lit_s;
    end
  end

  assign txd_fall = txd_prev_q && !txd_s;
  assign lit_rise = lit_s && !lit_prev_q;

  irx_mode_ctrl #(.SD_CYC(SD_CYC), .WAKE_CYC(WAKE_CYC)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .sd_s (sd_s),
    .mode (mode)
  );

  assign tx_allow = (mode == MODE_RUN);

  irx_eye_limit #(.EYE_CYC(EYE_CYC)) u_eye (
    .clk  (clk),
    .rst_n(rst_n),
    .txd_s(txd_s),
    .allow(tx_allow),
    .led_q(led_on)
  );

  always_comb begin
    rx_trig  = ((mode == MODE_RUN) && !txd_s && lit_rise) ||
               ((mode == MODE_SD_WAIT) && txd_fall);
    rx_clear = txd_s || (mode == MODE_OFF) || (mode == MODE_WAKE);
  end

  irx_rx_oneshot #(.PULSE_CYC(PULSE_CYC)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (rx_trig),
    .clear(rx_clear),
    .busy (rx_busy)
  );

  assign rxd_val = !rx_busy;
  assign rxd_oe  = (mode != MODE_OFF);

  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_oe |-> (!led_on && rxd_val)); // R9

  AST_RX_QUIET_TX: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> rxd_val); // R6

  AST_LED_AWAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> $past(mode == MODE_RUN)); // R8

endmodule

// File: tb/irtrx_ctrl_bench.sv
module irtrx_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam longint unsigned HZ = 10000000;
  localparam int S = 10000;
  localparam int W = 500;
  localparam int E = 400;
  localparam int P = 4;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n, txd_in, sd_in, light_in;
  logic led_on, rxd_val, rxd_oe;

  always #2.5 clk = ~clk;

  irtrx_ctrl #(.CLK_HZ(HZ)) u_irtrx_ctrl (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .sd_in(sd_in),
    .light_in(light_in), .led_on(led_on), .rxd_val(rxd_val), .rxd_oe(rxd_oe)
  );

  typedef struct {
    int    at;
    int    sig;
    logic  exp;
    string req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic get_sig(int s);
    case (s)
      0:       return led_on;
      1:       return rxd_val;
      default: return rxd_oe;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      0:       return "led_on";
      1:       return "rxd_val";
      default: return "rxd_oe";
    endcase
  endfunction

  task automatic compare(int s, logic e, string req);
    logic a;
    a = get_sig(s);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %b expected %b", req, sig_name(s), cyc, a, e);
    end
  endtask

  task automatic expect_at(int dt, int s, logic e, string req);
    item_t it;
    int i;
    it.at = cyc + dt; it.sig = s; it.exp = e; it.req = req;
    i = q.size();
    while (i > 0 && q[i-1].at > it.at) i--;
    q.insert(i, it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the expected items that fall due and compares them.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      compare(it.sig, it.exp, it.req);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog cycle %0d actual hung expected finish", cyc);
      finish_run();
    end
  end

  initial begin
    int t0;
    rst_n = 1'b0; txd_in = 1'b0; sd_in = 1'b0; light_in = 1'b0;
    step(5);
    compare(0, 1'b0, "R1");
    compare(1, 1'b1, "R1");
    compare(2, 1'b1, "R1");
    rst_n = 1'b1;
    step(1);
    compare(0, 1'b0, "R1");
    compare(1, 1'b1, "R1");
    compare(2, 1'b1, "R1");
    step(10);

    // R2: LED follows transmit data
    txd_in = 1'b1;
    expect_at(2, 0, 1'b0, "R2"); expect_at(3, 0, 1'b1, "R2");
    step(10);
    txd_in = 1'b0;
    expect_at(2, 0, 1'b1, "R2"); expect_at(3, 0, 1'b0, "R2");
    step(20);

    // R3: eye-safety cut-off and re-arm
    txd_in = 1'b1;
    expect_at(3, 0, 1'b1, "R3"); expect_at(2 + E, 0, 1'b1, "R3");
    expect_at(3 + E, 0, 1'b0, "R3"); expect_at(3 + E + 50, 0, 1'b0, "R3");
    step(E + 60);
    txd_in = 1'b0;
    step(10);
    txd_in = 1'b1;
    expect_at(3, 0, 1'b1, "R3");
    step(10);
    txd_in = 1'b0;
    step(20);

    // R4: light edge gives one fixed pulse
    light_in = 1'b1;
    expect_at(2, 1, 1'b1, "R4"); expect_at(3, 1, 1'b0, "R4");
    expect_at(2 + P, 1, 1'b0, "R4"); expect_at(3 + P, 1, 1'b1, "R4");
    expect_at(3 + P + 20, 1, 1'b1, "R4");
    step(40);
    light_in = 1'b0;
    expect_at(4, 1, 1'b1, "R4");
    step(10);

    // R5: second edge inside the pulse is ignored
    light_in = 1'b1;
    expect_at(3, 1, 1'b0, "R5"); expect_at(2 + P, 1, 1'b0, "R5");
    expect_at(3 + P, 1, 1'b1, "R5"); expect_at(8 + P, 1, 1'b1, "R5");
    step(1);
    light_in = 1'b0;
    step(1);
    light_in = 1'b1;
    step(30);
    light_in = 1'b0;
    step(10);

    // R6: blanking while transmitting
    txd_in = 1'b1;
    step(10);
    light_in = 1'b1;
    expect_at(3, 1, 1'b1, "R6"); expect_at(3 + P, 1, 1'b1, "R6");
    expect_at(3, 0, 1'b1, "R6");
    step(20);
    txd_in = 1'b0;
    expect_at(3, 1, 1'b1, "R6"); expect_at(3 + P, 1, 1'b1, "R6");
    step(20);
    light_in = 1'b0;
    step(10);

    // R7: short shutdown request leaves the block awake
    sd_in = 1'b1;
    expect_at(50, 2, 1'b1, "R7"); expect_at(110, 2, 1'b1, "R7");
    step(100);
    sd_in = 1'b0;
    step(20);
    light_in = 1'b1;
    expect_at(3, 1, 1'b0, "R7");
    step(20);
    light_in = 1'b0;
    step(10);

    // R7 and R8: full hold, identification pulse inside it
    t0 = cyc;
    sd_in = 1'b1;
    expect_at(2 + S, 2, 1'b1, "R7"); expect_at(3 + S, 2, 1'b0, "R7");
    step(20);
    txd_in = 1'b1;
    expect_at(3, 0, 1'b0, "R8"); expect_at(10, 0, 1'b0, "R8");
    step(20);
    txd_in = 1'b0;
    expect_at(2, 1, 1'b1, "R8"); expect_at(3, 1, 1'b0, "R8");
    expect_at(2 + P, 1, 1'b0, "R8"); expect_at(3 + P, 1, 1'b1, "R8");
    expect_at(13 + P, 1, 1'b1, "R8");
    while (cyc < t0 + S + 10) step(1);

    // R9: shutdown ignores all activity
    txd_in = 1'b1;
    expect_at(3, 0, 1'b0, "R9"); expect_at(3, 2, 1'b0, "R9");
    step(10);
    light_in = 1'b1;
    expect_at(3, 1, 1'b1, "R9"); expect_at(3 + P, 1, 1'b1, "R9");
    step(20);
    txd_in = 1'b0;
    light_in = 1'b0;
    expect_at(4, 1, 1'b1, "R9"); expect_at(4, 2, 1'b0, "R9");
    step(10);

    // R10: wake-up delay
    t0 = cyc;
    sd_in = 1'b0;
    expect_at(2, 2, 1'b0, "R10"); expect_at(3, 2, 1'b1, "R10");
    step(10);
    light_in = 1'b1;
    expect_at(3, 1, 1'b1, "R10"); expect_at(3 + P, 1, 1'b1, "R10");
    step(20);
    light_in = 1'b0;
    while (cyc < t0 + 3 + W + 10) step(1);
    light_in = 1'b1;
    expect_at(3, 1, 1'b0, "R10"); expect_at(3 + P, 1, 1'b1, "R10");
    step(20);
    light_in = 1'b0;
    step(20);

    while (q.size() > 0) step(1);
    step(2);
    finish_run();
  end

endmodule